// File: doc/BRIEF.md
# Branch and Next-PC Unit

This combinational unit picks the address of the next instruction for a 32-bit load/store core whose instructions are one aligned word each. It receives the current program counter, the primary opcode, the secondary register-select field, the short (16-bit) and long (26-bit) immediates, and the two register operand values. It evaluates the condition of the instruction in hand and returns either the sequential address, a PC-relative branch target or a region-relative jump target. It also raises a flag whenever the sequential path was left.

Conditional branches compare two registers for equality or inequality, or test the first operand against zero as a signed two's-complement value. The branch displacement counts in words from the instruction that follows the branch. The unconditional jump keeps the 256 MiB region of the current PC and replaces everything below it. Every address the unit produces is word aligned, whatever the two low bits of the incoming PC hold.

Top module: `bnpc_unit`

## Requirements
- R1: Opcode 4 is taken exactly when `rs_val_i` equals `rt_val_i`.
- R2: Opcode 5 is taken exactly when `rs_val_i` differs from `rt_val_i`.
- R3: Opcode 6 is taken when signed `rs_val_i` <= 0. Opcode 7 is taken when signed `rs_val_i` > 0.
- R4: Opcode 1 with `rt_sel_i` = 0 is taken when signed `rs_val_i` < 0. With `rt_sel_i` = 1 it is taken when signed `rs_val_i` >= 0. With any other `rt_sel_i` it is handled as a non-control instruction.
- R5: A taken branch goes to word(PC) + 4 + 4 × sign-extended `imm16_i`, modulo 2^32. PC 8 with offset 2 gives 20. PC 16 with offset -4 gives 4.
- R6: Opcode 2 is always taken. It goes to PC[31:28], then `imm26_i`, then two zero bits.
- R7: A branch that is not taken, or any opcode other than 1, 2, 4, 5, 6 or 7, yields word(PC) + 4 with `taken_o` = 0. This wraps from 0xFFFFFFFC to 0.
- R8: `next_pc_o[1:0]` is always 0. `pc_i[1:0]` has no effect on the result.
- R9: `taken_o` is 1 exactly when the result comes from a branch or jump target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pc_i | input | 32 | Address of the current instruction |
| opcode_i | input | 6 | Primary opcode field |
| rt_sel_i | input | 5 | Secondary register-select field; it picks the zero test when the opcode is 1 |
| imm16_i | input | 16 | Signed word offset for branches |
| imm26_i | input | 26 | Word index for jumps within the current region |
| rs_val_i | input | 32 | First register operand value |
| rt_val_i | input | 32 | Second register operand value |
| next_pc_o | output | 32 | Address of the next instruction |
| taken_o | output | 1 | High when the result is a branch or jump target |

## Verification
All 64 opcodes are applied, each with six operand pairs. The pairs are: both zero, equal nonzero, unequal, the most negative value, all ones against one, and the largest positive value. Together they separate equality from sign and zero tests, and show that unused opcodes fall through. For opcode 1, every value of the select field is swept, which shows that only 0 and 1 act as branches.

Directed cases check the following:
- the two worked offsets and both extremes of the displacement;
- a jump from a high region, so a carry into the region bits would show;
- a sequential wrap at the top of memory;
- PCs with nonzero low bits, which show whether the alignment is forced.

// File: rtl/bnpc_pkg.sv
package bnpc_pkg;

    localparam int XLEN       = 32;
    localparam int OPC_W      = 6;
    localparam int RSEL_W     = 5;
    localparam int IMM_S_W    = 16;
    localparam int IMM_L_W    = 26;
    localparam int WORD_SHIFT = 2;
    localparam int WADDR_W    = XLEN - WORD_SHIFT;
    localparam int REGION_W   = XLEN - IMM_L_W - WORD_SHIFT;

    localparam logic [OPC_W-1:0] OPC_ZCMP = 6'd1;
    localparam logic [OPC_W-1:0] OPC_JMP  = 6'd2;
    localparam logic [OPC_W-1:0] OPC_EQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_NE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_LEZ  = 6'd6;
    localparam logic [OPC_W-1:0] OPC_GTZ  = 6'd7;

    localparam logic [RSEL_W-1:0] ZSEL_LT = 5'd0;
    localparam logic [RSEL_W-1:0] ZSEL_GE = 5'd1;

    typedef enum logic [1:0] {
        FLOW_SEQ,
        FLOW_BRANCH,
        FLOW_JUMP
    } flow_e;

    typedef enum logic [2:0] {
        CMP_NONE,
        CMP_EQ,
        CMP_NE,
        CMP_LEZ,
        CMP_GTZ,
        CMP_LTZ,
        CMP_GEZ
    } cmp_e;

    typedef struct packed {
        flow_e flow;
        cmp_e  cmp;
    } ctl_t;

    typedef struct packed {
        logic [WADDR_W-1:0] seq_w;
        logic [WADDR_W-1:0] br_w;
        logic [WADDR_W-1:0] jmp_w;
    } tgt_t;

    // Widen a signed word offset to the width of a word address.
    function automatic logic [WADDR_W-1:0] widen_offset(input logic [IMM_S_W-1:0] off);
        return {{(WADDR_W-IMM_S_W){off[IMM_S_W-1]}}, off};
    endfunction

    // Append the zero byte-offset bits to a word address.
    function automatic logic [XLEN-1:0] to_byte_addr(input logic [WADDR_W-1:0] w);
        return {w, {WORD_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/bnpc_decode.sv
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic [RSEL_W-1:0] rt_sel_i,
    output ctl_t              ctl_o
);

    always_comb begin
        ctl_o.flow = FLOW_SEQ;
        ctl_o.cmp  = CMP_NONE;
        unique case (opcode_i)
            OPC_JMP: ctl_o.flow = FLOW_JUMP;
            OPC_EQ:  begin ctl_o.flow = FLOW_BRANCH; ctl_o.cmp = CMP_EQ;  end
            OPC_NE:  begin ctl_o.flow = FLOW_BRANCH; ctl_o.cmp = CMP_NE;  end
            OPC_LEZ: begin ctl_o.flow = FLOW_BRANCH; ctl_o.cmp = CMP_LEZ; end
            OPC_GTZ: begin ctl_o.flow = FLOW_BRANCH; ctl_o.cmp = CMP_GTZ; end
            OPC_ZCMP: begin
                if (rt_sel_i == ZSEL_LT) begin
                    ctl_o.flow = FLOW_BRANCH;
                    ctl_o.cmp  = CMP_LTZ;
                end else if (rt_sel_i == ZSEL_GE) begin
                    ctl_o.flow = FLOW_BRANCH;
                    ctl_o.cmp  = CMP_GEZ;
                end
            end
            default: ;
        endcase
    end

    // Only branches carry a condition; other flows never do.
    always_comb begin
        assert_cmp_only_on_branch_R4: assert ((ctl_o.flow == FLOW_BRANCH) == (ctl_o.cmp != CMP_NONE))
            else $error("decode produced a condition without a branch");
    end

endmodule

// File: rtl/bnpc_cond.sv
module bnpc_cond
    import bnpc_pkg::*;
(
    input  cmp_e            cmp_i,
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic            pass_o
);

    logic a_zero;
    logic a_neg;
    logic a_eq_b;

    assign a_zero = (a_i == '0);
    assign a_neg  = a_i[XLEN-1];
    assign a_eq_b = (a_i == b_i);

    always_comb begin
        unique case (cmp_i)
            CMP_EQ:  pass_o = a_eq_b;
            CMP_NE:  pass_o = !a_eq_b;
            CMP_LEZ: pass_o = a_neg || a_zero;
            CMP_GTZ: pass_o = !a_neg && !a_zero;
            CMP_LTZ: pass_o = a_neg;
            CMP_GEZ: pass_o = !a_neg;
            default: pass_o = 1'b0;
        endcase
    end

    // Sign tests against zero agree with a signed comparison.
    always_comb begin
        assert_gtz_signed_R3: assert (!(cmp_i == CMP_GTZ) || (pass_o == ($signed(a_i) > 0)))
            else $error("greater-than-zero test disagrees with signed compare");
        assert_ltz_signed_R4: assert (!(cmp_i == CMP_LTZ) || (pass_o == ($signed(a_i) < 0)))
            else $error("less-than-zero test disagrees with signed compare");
    end

endmodule

// File: rtl/bnpc_target.sv
module bnpc_target
    import bnpc_pkg::*;
(
    input  logic [XLEN-1:0]    pc_i,
    input  logic [IMM_S_W-1:0] imm16_i,
    input  logic [IMM_L_W-1:0] imm26_i,
    output tgt_t               tgt_o
);

    logic [WADDR_W-1:0] pc_w;
    logic               unused_pc_lo;

    assign pc_w         = pc_i[XLEN-1:WORD_SHIFT];
    assign unused_pc_lo = ^pc_i[WORD_SHIFT-1:0];

    assign tgt_o.seq_w = pc_w + WADDR_W'(1);
    assign tgt_o.br_w  = tgt_o.seq_w + widen_offset(imm16_i);

    generate
        if (REGION_W > 0) begin : g_region
            assign tgt_o.jmp_w = {pc_w[WADDR_W-1 -: REGION_W], imm26_i};
        end else begin : g_flat
            assign tgt_o.jmp_w = WADDR_W'(imm26_i);
        end
    endgenerate

    // The branch target sits exactly one word past the current PC when the offset is zero.
    always_comb begin
        assert_zero_offset_R5: assert (!(imm16_i == '0) || (tgt_o.br_w == tgt_o.seq_w))
            else $error("zero offset did not land on the next word");
    end

endmodule

// File: rtl/bnpc_unit.sv
module bnpc_unit
    import bnpc_pkg::*;
(
    input  logic [31:0] pc_i,
    input  logic [5:0]  opcode_i,
    input  logic [4:0]  rt_sel_i,
    input  logic [15:0] imm16_i,
    input  logic [25:0] imm26_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] next_pc_o,
    output logic        taken_o
);

    ctl_t ctl;
    tgt_t tgt;
    logic cond_pass;
    logic [WADDR_W-1:0] next_w;

    bnpc_decode u_decode (
        .opcode_i (opcode_i),
        .rt_sel_i (rt_sel_i),
        .ctl_o    (ctl)
    );

    bnpc_cond u_cond (
        .cmp_i  (ctl.cmp),
        .a_i    (rs_val_i),
        .b_i    (rt_val_i),
        .pass_o (cond_pass)
    );

    bnpc_target u_target (
        .pc_i    (pc_i),
        .imm16_i (imm16_i),
        .imm26_i (imm26_i),
        .tgt_o   (tgt)
    );

    always_comb begin
        unique case (ctl.flow)
            FLOW_JUMP: begin
                taken_o = 1'b1;
                next_w  = tgt.jmp_w;
            end
            FLOW_BRANCH: begin
                taken_o = cond_pass;
                next_w  = cond_pass ? tgt.br_w : tgt.seq_w;
            end
            default: begin
                taken_o = 1'b0;
                next_w  = tgt.seq_w;
            end
        endcase
    end

    assign next_pc_o = to_byte_addr(next_w);

    always_comb begin
        assert_word_aligned_R8: assert (next_pc_o[1:0] == 2'b00)
            else $error("next PC not word aligned");
        assert_fallthrough_R7: assert (taken_o || (next_pc_o[31:2] == pc_i[31:2] + 30'd1))
            else $error("untaken path did not advance one word");
        assert_jump_region_R6: assert (!(opcode_i == OPC_JMP) || (taken_o && next_pc_o[31:28] == pc_i[31:28]))
            else $error("jump left its region or was not taken");
        assert_seq_not_taken_R9: assert (!(ctl.flow == FLOW_SEQ) || !taken_o)
            else $error("non-control instruction flagged as taken");
    end

endmodule

// File: tb/bnpc_unit_bench.sv
module bnpc_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] pc_i = '0;
    logic [5:0]  opcode_i = '0;
    logic [4:0]  rt_sel_i = '0;
    logic [15:0] imm16_i = '0;
    logic [25:0] imm26_i = '0;
    logic [31:0] rs_val_i = '0;
    logic [31:0] rt_val_i = '0;
    logic [31:0] next_pc_o;
    logic        taken_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    bnpc_unit u_bnpc_unit (
        .pc_i      (pc_i),
        .opcode_i  (opcode_i),
        .rt_sel_i  (rt_sel_i),
        .imm16_i   (imm16_i),
        .imm26_i   (imm26_i),
        .rs_val_i  (rs_val_i),
        .rt_val_i  (rt_val_i),
        .next_pc_o (next_pc_o),
        .taken_o   (taken_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    function automatic bit model_taken(input logic [5:0] opc, input logic [4:0] sel,
                                       input logic [31:0] a, input logic [31:0] b);
        case (opc)
            6'd2: return 1'b1;
            6'd4: return a == b;
            6'd5: return a != b;
            6'd6: return $signed(a) <= 0;
            6'd7: return $signed(a) > 0;
            6'd1: begin
                if (sel == 5'd0) return $signed(a) < 0;
                if (sel == 5'd1) return $signed(a) >= 0;
                return 1'b0;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_next(input logic [31:0] pc, input logic [5:0] opc,
                                               input bit tk, input logic [15:0] i16,
                                               input logic [25:0] i26);
        logic [31:0] base;
        logic [31:0] disp;
        base = pc & 32'hFFFF_FFFC;
        disp = {{16{i16[15]}}, i16} * 32'd4;
        if (!tk) return base + 32'd4;
        if (opc == 6'd2) return (pc & 32'hF000_0000) | ({6'd0, i26} * 32'd4);
        return base + 32'd4 + disp;
    endfunction

    function automatic string req_of(input logic [5:0] opc);
        case (opc)
            6'd1: return "R4";
            6'd2: return "R6";
            6'd4: return "R1";
            6'd5: return "R2";
            6'd6, 6'd7: return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic run_case(input string req, input logic [31:0] pc, input logic [5:0] opc,
                            input logic [4:0] sel, input logic [15:0] i16, input logic [25:0] i26,
                            input logic [31:0] a, input logic [31:0] b);
        bit tk;
        @(posedge clk);
        pc_i = pc; opcode_i = opc; rt_sel_i = sel; imm16_i = i16; imm26_i = i26;
        rs_val_i = a; rt_val_i = b;
        tk = model_taken(opc, sel, a, b);
        @(negedge clk);
        check({req, " next_pc"}, next_pc_o, model_next(pc, opc, tk, i16, i26));
        check({req, "/R9 taken"}, {31'd0, taken_o}, {31'd0, tk});
    endtask

    logic [31:0] pair_a [6] = '{32'd0, 32'd5, 32'd5, 32'h8000_0000, 32'hFFFF_FFFF, 32'h7FFF_FFFF};
    logic [31:0] pair_b [6] = '{32'd0, 32'd5, 32'd6, 32'd0,         32'd1,         32'd1};

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle inputs after reset: opcode 0, PC 0 -> sequential address 4.
        @(negedge clk);
        check("R7 reset next_pc", next_pc_o, 32'd4);
        check("R7 reset taken", {31'd0, taken_o}, 32'd0);

        // Full opcode sweep with several operand pairs (R1, R2, R3, R4, R6, R7).
        for (int op = 0; op < 64; op++) begin
            for (int k = 0; k < 6; k++) begin
                run_case(req_of(6'(op)), 32'h1234_5678 + 32'(k * 4), 6'(op), 5'(k), 16'hFFF0 + 16'(k),
                         26'h2AB_CDEF, pair_a[k], pair_b[k]);
            end
        end

        // Select field sweep for opcode 1 (R4).
        for (int s = 0; s < 32; s++) begin
            for (int k = 0; k < 5; k++) begin
                run_case("R4", 32'h0000_4000, 6'd1, 5'(s), 16'd7, 26'd0, pair_a[k + 1], 32'd0);
            end
        end

        // Worked offsets and displacement extremes (R5).
        run_case("R5", 32'd8, 6'd4, 5'd0, 16'd2, 26'd0, 32'd9, 32'd9);
        check("R5 example A", next_pc_o, 32'd20);
        run_case("R5", 32'd16, 6'd4, 5'd0, 16'hFFFC, 26'd0, 32'd1, 32'd1);
        check("R5 example B", next_pc_o, 32'd4);
        run_case("R5", 32'h0010_0000, 6'd5, 5'd0, 16'h7FFF, 26'd0, 32'd1, 32'd2);
        run_case("R5", 32'h0010_0000, 6'd5, 5'd0, 16'h8000, 26'd0, 32'd1, 32'd2);
        run_case("R5", 32'd0, 6'd7, 5'd0, 16'hFFFE, 26'd0, 32'd3, 32'd0);

        // Jump from a high region with all-ones index (R6).
        run_case("R6", 32'hEFFF_FFFC, 6'd2, 5'd0, 16'd0, 26'h3FF_FFFF, 32'd0, 32'd0);
        check("R6 region kept", next_pc_o, 32'hEFFF_FFFC);

        // Sequential wrap at the top of memory (R7).
        run_case("R7", 32'hFFFF_FFFC, 6'd0, 5'd0, 16'd0, 26'd0, 32'd0, 32'd0);
        check("R7 wrap", next_pc_o, 32'd0);

        // Low PC bits set: results stay aligned and unaffected (R8).
        for (int lo = 0; lo < 4; lo++) begin
            run_case("R8", 32'h0000_1000 + 32'(lo), 6'd4, 5'd0, 16'd3, 26'd0, 32'd1, 32'd1);
            check("R8 aligned branch", next_pc_o, 32'h0000_1010);
            run_case("R8", 32'h0000_1000 + 32'(lo), 6'd9, 5'd0, 16'd3, 26'd0, 32'd1, 32'd1);
            check("R8 aligned sequential", next_pc_o, 32'h0000_1004);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule